// File: doc/BRIEF.md
# Sequential Kernel Launch Controller

This block sits between a host bus and one compute kernel, and runs that kernel one execution at a time. The host reaches it through an AXI4-Lite slave port. A single 32-bit word at byte offset 0x0 carries both the command and the status. When the host writes a 1 to the start bit, the controller raises `kern_start` toward the kernel. It then watches the kernel's `kern_idle` and `kern_done` lines and shows the progress of the run in the same word.

The block launches a new run only while no run is active, so queued requests finish strictly in the order start, done, start, done. The host polls the word and waits for the done bit before it issues the next start. Reading the word while it shows done also clears done. The parameter `START_PULSE` selects how `kern_start` is driven: held high for the whole run (the default), or a single-cycle pulse.

Top module: `seq_kctl`

## Requirements
- R1: The word at offset 0x0 reads start at bit 0, done at bit 1, idle at bit 2, and zero in bits 31:3. After reset it reads 0x00000004 and `kern_start` is low.
- R2: A write to word 0 with `wstrb[0]`=1 and `wdata[0]`=1 while idle launches a run. `kern_start` is high by the cycle after the write response is accepted, and the word reads 0x1 (start=1, idle=0).
- R3: The start bit stays 1 until the kernel drives `kern_idle` low. The start bit then clears by itself, and the word reads 0x0 while the run is active.
- R4: A one-cycle `kern_done` during a run ends it. The word reads 0x6 (done=1, idle=1) and `kern_start` is low. This also holds when `kern_done` arrives before the kernel has dropped `kern_idle`.
- R5: A start write while a run is active is ignored. No new `kern_start` rise occurs, the word is unchanged, and runs strictly alternate launch and completion.
- R6: The done bit clears only when a read of word 0 returns it as 1. It persists over idle cycles, and a host write to bit 1 never sets it.
- R7: A write to word 0 with `wstrb[0]`=0 has no effect on the word or on `kern_start`.
- R8: Writes to any nonzero word address have no effect. Reads there return 0. Every write and read response is OKAY (2'b00).
- R9: Write address and write data are accepted in either order or in the same cycle, with identical effect.
- R10: With `START_PULSE`=0, `kern_start` stays high from launch until completion. With `START_PULSE`=1, it is high for exactly one cycle per launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| kern_start | output | 1 | Launch request to the kernel |
| kern_done | input | 1 | Kernel completion pulse |
| kern_idle | input | 1 | Kernel idle; low means the request was taken |

## Verification
The assertions check, on every cycle, the relations between successive states:
- a launch only ever leaves the idle state;
- acceptance clears the start bit;
- `kern_done` sets the done bit and returns the controller to idle;
- a read that returns done clears it;
- `kern_start` keeps its level or pulse shape;
- the response channels hold steady under back-pressure.

Only the bench scenarios can show the following:
- the exact register values the host sees;
- that start writes while busy, strobe-masked writes and writes to other addresses leave no trace;
- that the three orderings of address and data phases give the same result;
- that repeated runs alternate launch and completion.

// File: rtl/seq_kctl_pkg.sv
package seq_kctl_pkg;
   typedef enum logic [1:0] {
      SK_IDLE   = 2'd0,
      SK_LAUNCH = 2'd1,
      SK_RUN    = 2'd2
   } sk_state_e;

   localparam int unsigned SK_BIT_START = 0;
   localparam int unsigned SK_BIT_DONE  = 1;
   localparam int unsigned SK_BIT_IDLE  = 2;
   localparam logic [1:0]  SK_RESP_OKAY = 2'b00;
endpackage

// File: rtl/skc_wr_port.sv
module skc_wr_port #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   output logic              wr_fire,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [STRB_W-1:0] wr_strb
);
   import seq_kctl_pkg::*;

   logic aw_full, w_full;

   assign awready = !aw_full;
   assign wready  = !w_full;
   assign wr_fire = aw_full && w_full && !bvalid;
   assign bresp   = SK_RESP_OKAY;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aw_full <= 1'b0;
         w_full  <= 1'b0;
         bvalid  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         wr_strb <= '0;
      end else begin
         if (awvalid && awready) begin
            aw_full <= 1'b1;
            wr_addr <= awaddr;
         end
         if (wvalid && wready) begin
            w_full  <= 1'b1;
            wr_data <= wdata;
            wr_strb <= wstrb;
         end
         if (wr_fire) begin
            aw_full <= 1'b0;
            w_full  <= 1'b0;
            bvalid  <= 1'b1;
         end else if (bvalid && bready) begin
            bvalid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/skc_rd_port.sv
module skc_rd_port #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned WORD_LSB = $clog2(DATA_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   input  logic [DATA_W-1:0] status,
   output logic              rd_clr_done
);
   import seq_kctl_pkg::*;

   logic ar_hit, ar_word0;

   assign arready     = !rvalid;
   assign rresp       = SK_RESP_OKAY;
   assign ar_hit      = arvalid && arready;
   assign ar_word0    = (araddr[ADDR_W-1:WORD_LSB] == '0);
   assign rd_clr_done = ar_hit && ar_word0 && status[SK_BIT_DONE];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else if (ar_hit) begin
         rvalid <= 1'b1;
         rdata  <= ar_word0 ? status : '0;
      end else if (rvalid && rready) begin
         rvalid <= 1'b0;
      end
   end
endmodule

// File: rtl/skc_seq.sv
module skc_seq #(
   parameter bit START_PULSE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_req,
   input  logic clr_done,
   input  logic kern_done,
   input  logic kern_idle,
   output logic kern_start,
   output logic st_start,
   output logic st_done,
   output logic st_idle
);
   import seq_kctl_pkg::*;

   sk_state_e state_q, state_d;
   logic      done_set;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SK_IDLE:   if (go_req) state_d = SK_LAUNCH;
         SK_LAUNCH: begin
            if (kern_done)      state_d = SK_IDLE;
            else if (!kern_idle) state_d = SK_RUN;
         end
         SK_RUN:    if (kern_done) state_d = SK_IDLE;
         default:   state_d = SK_IDLE;
      endcase
   end

   assign done_set = (state_q != SK_IDLE) && kern_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SK_IDLE;
         st_done <= 1'b0;
      end else begin
         state_q <= state_d;
         if (done_set)      st_done <= 1'b1;
         else if (clr_done) st_done <= 1'b0;
      end
   end

   assign st_start = (state_q == SK_LAUNCH);
   assign st_idle  = (state_q == SK_IDLE);

   generate
      if (START_PULSE) begin : g_pulse
         logic pulse_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= (state_q == SK_IDLE) && go_req;
         end
         assign kern_start = pulse_q;
      end else begin : g_level
         assign kern_start = (state_q != SK_IDLE);
      end
   endgenerate
endmodule

// File: rtl/seq_kctl.sv
module seq_kctl #(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned DATA_W      = 32,
   parameter bit          START_PULSE = 1'b0,
   localparam int unsigned STRB_W   = DATA_W / 8,
   localparam int unsigned WORD_LSB = $clog2(STRB_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic [STRB_W-1:0] s_wstrb,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic              kern_start,
   input  logic              kern_done,
   input  logic              kern_idle
);
   import seq_kctl_pkg::*;

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("seq_kctl: DATA_W must be 32");
      end
      if (ADDR_W <= WORD_LSB) begin : g_bad_addr_w
         $error("seq_kctl: ADDR_W too small for a word address");
      end
   endgenerate

   logic              wr_fire;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [STRB_W-1:0] wr_strb;
   logic              go_req, rd_clr;
   logic              st_start, st_done, st_idle;
   logic [DATA_W-1:0] status;

   skc_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk(clk), .rst_n(rst_n),
      .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
      .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
      .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
      .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
   );

   assign go_req = wr_fire && (wr_addr[ADDR_W-1:WORD_LSB] == '0)
                   && wr_strb[0] && wr_data[SK_BIT_START];

   always_comb begin
      status               = '0;
      status[SK_BIT_START] = st_start;
      status[SK_BIT_DONE]  = st_done;
      status[SK_BIT_IDLE]  = st_idle;
   end

   skc_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .clk(clk), .rst_n(rst_n),
      .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
      .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
      .status(status), .rd_clr_done(rd_clr)
   );

   skc_seq #(.START_PULSE(START_PULSE)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .go_req(go_req), .clr_done(rd_clr),
      .kern_done(kern_done), .kern_idle(kern_idle),
      .kern_start(kern_start),
      .st_start(st_start), .st_done(st_done), .st_idle(st_idle)
   );
endmodule

// File: rtl/seq_kctl_chk.sv
module seq_kctl_chk #(
   parameter bit          START_PULSE = 1'b0,
   parameter int unsigned DATA_W      = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bvalid,
   input logic              bready,
   input logic              rvalid,
   input logic              rready,
   input logic [DATA_W-1:0] rdata,
   input logic              kern_start,
   input logic              kern_done,
   input logic              kern_idle,
   input logic              st_start,
   input logic              st_done,
   input logic              st_idle,
   input logic              clr_done
);
   // R5
   launch_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_start) |-> $past(st_idle));

   // R3
   accept_clears_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_start && !kern_idle && !kern_done |=> !st_start && !st_idle);

   // R4
   done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st_idle && kern_done |=> st_done && st_idle);

   // R6
   done_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_done && clr_done && !(kern_done && !st_idle) |=> !st_done);

   // R8
   bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid && !bready |=> bvalid);

   // R8
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid && !rready |=> rvalid && $stable(rdata));

   generate
      if (START_PULSE) begin : g_pulse_chk
         // R10
         start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            kern_start |=> !kern_start);
      end else begin : g_level_chk
         // R10
         start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !st_idle |-> kern_start);
         // R10
         start_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_idle |-> !kern_start);
      end
   endgenerate
endmodule

bind seq_kctl seq_kctl_chk #(.START_PULSE(START_PULSE), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .bvalid(s_bvalid), .bready(s_bready),
   .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata),
   .kern_start(kern_start), .kern_done(kern_done), .kern_idle(kern_idle),
   .st_start(st_start), .st_done(st_done), .st_idle(st_idle),
   .clr_done(rd_clr)
);

// File: tb/seq_kctl_bench.sv
module seq_kctl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  awaddr = '0, araddr = '0;
   logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
   logic        bready = 1'b1, rready = 1'b1;
   logic [31:0] wdata = '0;
   logic [3:0]  wstrb = '0;
   logic        awready, wready, bvalid, arready, rvalid;
   logic [1:0]  bresp, rresp;
   logic [31:0] rdata;
   logic        kern_start;
   logic        kern_done = 1'b0, kern_idle = 1'b1;

   int tests = 0, fails = 0, launches = 0;
   logic ks_q = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   seq_kctl u_seq_kctl (
      .clk(clk), .rst_n(rst_n),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
      .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
      .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
      .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
      .kern_start(kern_start), .kern_done(kern_done), .kern_idle(kern_idle)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // launch counter: kern_start rising edges seen away from the clock edge
   always @(negedge clk) begin
      if (kern_start && !ks_q) launches++;
      ks_q = kern_start;
   end

   // scoreboard monitor for read data
   always @(negedge clk) begin
      if (rvalid && rready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "unexpected read", rdata, 32'h0);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rdata === e, t, rdata, e);
            check(rresp === 2'b00, "R8 rresp", {30'd0, rresp}, 32'h0);
         end
      end
   end

   task automatic axi_wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s, input int mode);
      awaddr = a; wdata = d; wstrb = s;
      if (mode == 0) begin
         awvalid = 1'b1; wvalid = 1'b1;
         while (!(awready && wready)) @(negedge clk);
         @(negedge clk);
         awvalid = 1'b0; wvalid = 1'b0;
      end else if (mode == 1) begin
         awvalid = 1'b1;
         while (!awready) @(negedge clk);
         @(negedge clk); awvalid = 1'b0;
         @(negedge clk);
         wvalid = 1'b1;
         while (!wready) @(negedge clk);
         @(negedge clk); wvalid = 1'b0;
      end else begin
         wvalid = 1'b1;
         while (!wready) @(negedge clk);
         @(negedge clk); wvalid = 1'b0;
         @(negedge clk);
         awvalid = 1'b1;
         while (!awready) @(negedge clk);
         @(negedge clk); awvalid = 1'b0;
      end
      while (!bvalid) @(negedge clk);
      check(bresp === 2'b00, "R8 bresp", {30'd0, bresp}, 32'h0);
      @(negedge clk);
   endtask

   task automatic axi_rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      araddr = a; arvalid = 1'b1;
      while (!arready) @(negedge clk);
      @(negedge clk); arvalid = 1'b0;
      @(negedge clk);
   endtask

   task automatic kern_accept();
      kern_idle = 1'b0;
      @(negedge clk); @(negedge clk);
   endtask

   task automatic kern_finish();
      kern_done = 1'b1; kern_idle = 1'b1;
      @(negedge clk);
      kern_done = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(kern_start === 1'b0, "R1 kern_start after reset", {31'd0, kern_start}, 32'h0);
      axi_rd(6'h00, 32'h4, "R1 reset status");

      // R2 launch, R10 level start
      axi_wr(6'h00, 32'h1, 4'hF, 0);
      check(kern_start === 1'b1, "R2 kern_start after launch", {31'd0, kern_start}, 32'h1);
      check(launches == 1, "R2 one launch", launches, 1);
      axi_rd(6'h00, 32'h1, "R2 status pending");

      // R3 acceptance clears the start bit
      kern_accept();
      axi_rd(6'h00, 32'h0, "R3 status running");
      check(kern_start === 1'b1, "R10 kern_start held while running", {31'd0, kern_start}, 32'h1);

      // R5 start while busy is ignored
      axi_wr(6'h00, 32'h1, 4'hF, 1);
      axi_rd(6'h00, 32'h0, "R5 status unchanged");
      check(launches == 1, "R5 no extra launch", launches, 1);

      // R4 completion
      kern_finish();
      check(kern_start === 1'b0, "R4 kern_start low after done", {31'd0, kern_start}, 32'h0);
      repeat (4) @(negedge clk);
      axi_rd(6'h00, 32'h6, "R6 done persists and reads");
      axi_rd(6'h00, 32'h4, "R6 done cleared by read");

      // R6 writing bit 1 does not set done
      axi_wr(6'h00, 32'h2, 4'hF, 0);
      axi_rd(6'h00, 32'h4, "R6 done not writable");

      // R7 strobe masked start
      axi_wr(6'h00, 32'h1, 4'hE, 2);
      axi_rd(6'h00, 32'h4, "R7 masked write ignored");
      check(kern_start === 1'b0, "R7 no launch", {31'd0, kern_start}, 32'h0);

      // R8 other addresses
      axi_wr(6'h08, 32'h1, 4'hF, 0);
      axi_rd(6'h00, 32'h4, "R8 write elsewhere ignored");
      axi_rd(6'h08, 32'h0, "R8 read elsewhere zero");
      check(launches == 1, "R8 no launch from other address", launches, 1);

      // R9 / R5 sequential runs with all phase orders
      base = launches;
      for (int i = 0; i < 3; i++) begin
         axi_wr(6'h00, 32'h1, 4'h1, (i + 1) % 3);
         check(launches == base + i + 1, "R9 launch per run", launches, base + i + 1);
         check(kern_start === 1'b1, "R10 kern_start at launch", {31'd0, kern_start}, 32'h1);
         axi_rd(6'h00, 32'h1, "R9 status pending");
         kern_accept();
         axi_rd(6'h00, 32'h0, "R9 status running");
         kern_finish();
         axi_rd(6'h00, 32'h6, "R5 done before next start");
      end

      // R4 done before acceptance
      axi_wr(6'h00, 32'h1, 4'h1, 0);
      axi_rd(6'h00, 32'h1, "R4 pending before early done");
      kern_finish();
      check(kern_start === 1'b0, "R4 early done stops start", {31'd0, kern_start}, 32'h0);
      axi_rd(6'h00, 32'h6, "R4 early done status");
      axi_rd(6'h00, 32'h4, "R6 cleared after early done");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule